// File: doc/BRIEF.md
# Sparse-Tap Multipath Channel Emulator

This block stands in for the radio channel between one transmitter and one receiver. A stream of complex baseband samples, one per clock, enters a circular history buffer. The block models a set of reflection paths, each with its own delay and its own complex gain. For every output sample it reads each path's delayed copy of the input from the history buffer and multiplies that copy by the path's gain. It then adds all path products together, rounds the sum and saturates it to one complex output sample. Unlike a dense FIR filter, the taps sit at arbitrary, separately programmed positions anywhere in a deep history.

Path settings are written into a shadow bank through a small address/data port while traffic keeps flowing. A single commit strobe moves the whole shadow bank into the active bank at once. Because the active settings are captured with each sample as it is accepted, every output sample is built entirely from one path set. Each path can also be switched off without touching its delay or gain. Input and output use valid/ready handshakes around a fixed three-stage pipeline.

Top module: `mpath_chan_emu`

## Requirements
- R1: After reset out_valid is 0, in_ready is 1, every path is disabled, and samples accepted before any commit produce zero outputs.
- R2: Output n equals the sum over enabled paths p of x[n-D_p]·g_p, with (a+jb)(c+jd) = (ac−bd) + j(ad+bc). Here x is the input (I, Q), D_p is the path delay in samples and g_p is the Q1.15 gain.
- R3: The complex sum is rounded by adding 2^14 and shifting right arithmetically by 15. The result saturates to the range −32768..32767 on each component.
- R4: A history position that has not yet been written since reset reads as zero: a path with delay D contributes nothing to sample n when n < D (n counts accepted samples from 0).
- R5: A written delay value is clamped to the range MIN_DELAY..DEPTH−1 (MIN_DELAY ≥ 1), with the full 32-bit write data compared as unsigned.
- R6: Shadow writes have no effect on the output until a commit. A commit applies to the first sample accepted after the commit cycle, and a sample accepted in the same cycle as the commit still uses the old set.
- R7: A disabled path contributes zero. It keeps its stored delay and gain, so re-enabling it restores its old contribution.
- R8: With out_ready high, a sample accepted on clock edge k raises out_valid after edge k+2 (LATENCY = 3 edges), and every accepted sample yields exactly one output in order.
- R9: While out_valid is 1 and out_ready is 0, out_valid, out_i and out_q hold steady and in_ready is 0.
- R10: The configuration address is {path index, field}, with the field in the low 2 bits. Field 0 is the delay, field 1 is the gain (I in bits 31:16, Q in bits 15:0) and field 2 is the enable (bit 0). Field 3 writes and writes to path indices ≥ NPATHS change nothing.
- R11: The history buffer is circular, so delays up to DEPTH−1 stay correct after the write position has wrapped any number of times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept an input sample |
| in_i | input | 16 | Input in-phase component, signed |
| in_q | input | 16 | Input quadrature component, signed |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts the output sample |
| out_i | output | 16 | Output in-phase component, signed |
| out_q | output | 16 | Output quadrature component, signed |
| cfg_we | input | 1 | Shadow bank write enable |
| cfg_addr | input | clog2(NPATHS)+2 | Path index and field select |
| cfg_wdata | input | 32 | Shadow bank write data |
| cfg_commit | input | 1 | Copy the shadow bank into the active bank |

## Verification
The bench builds the block with NPATHS = 3, DEPTH = 16 and MIN_DELAY = 2. This shallow history lets the write position wrap several times within a few dozen samples, so the longest delay of 15 is exercised across many wraps. It also lets a write of 1 and a write of 100 hit both ends of the delay clamp. Three paths at full-scale gain drive the sum well beyond 16 bits, which reaches saturation in both directions, while a single one-LSB gain exposes the rounding boundary exactly.

// File: rtl/mpe_pkg.sv
package mpe_pkg;

  localparam int SW   = 16;
  localparam int PW   = 34;
  localparam int ACCW = 48;
  localparam int FRAC = 15;
  localparam int SMAX = (2 ** (SW - 1)) - 1;
  localparam int SMIN = -(2 ** (SW - 1));

  typedef logic signed [SW-1:0] smp_t;

  typedef struct packed {
    logic signed [SW-1:0] re;
    logic signed [SW-1:0] im;
  } cplx_t;

  typedef enum logic [1:0] {
    F_DELAY  = 2'd0,
    F_GAIN   = 2'd1,
    F_ENABLE = 2'd2,
    F_SPARE  = 2'd3
  } field_e;

  // Real part of x * g
  function automatic logic signed [PW-1:0] cmul_re(cplx_t x, cplx_t g);
    logic signed [PW-1:0] a, b, c, d;
    a = PW'($signed(x.re));
    b = PW'($signed(x.im));
    c = PW'($signed(g.re));
    d = PW'($signed(g.im));
    return (a * c) - (b * d);
  endfunction

  // Imaginary part of x * g
  function automatic logic signed [PW-1:0] cmul_im(cplx_t x, cplx_t g);
    logic signed [PW-1:0] a, b, c, d;
    a = PW'($signed(x.re));
    b = PW'($signed(x.im));
    c = PW'($signed(g.re));
    d = PW'($signed(g.im));
    return (a * d) + (b * c);
  endfunction

  // Round half up at bit FRAC, then clip to the sample range
  function automatic smp_t rnd_sat(logic signed [ACCW-1:0] acc);
    logic signed [ACCW-1:0] t;
    t = (acc + ACCW'(2 ** (FRAC - 1))) >>> FRAC;
    if (t > ACCW'(SMAX)) return SW'(SMAX);
    if (t < ACCW'(SMIN)) return SW'(SMIN);
    return t[SW-1:0];
  endfunction

  function automatic logic [31:0] clamp_dly(logic [31:0] v, int unsigned lo, int unsigned hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/mpe_pathbank.sv
module mpe_pathbank
  import mpe_pkg::*;
#(
  parameter int NPATHS    = 10,
  parameter int DEPTH     = 1024,
  parameter int MIN_DELAY = 4,
  localparam int PIW = (NPATHS > 1) ? $clog2(NPATHS) : 1,
  localparam int CAW = PIW + 2,
  localparam int DLW = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [CAW-1:0]                cfg_addr,
  input  logic [31:0]                   cfg_wdata,
  input  logic                          cfg_commit,
  output logic [NPATHS-1:0]             act_en,
  output logic [NPATHS-1:0][DLW-1:0]    act_dly,
  output cplx_t [NPATHS-1:0]            act_gain
);

  field_e                       fld;
  logic [PIW-1:0]               pidx;
  logic [DLW-1:0]               wr_dly;
  cplx_t                        wr_gain;
  logic [NPATHS-1:0]            path_hit;
  logic [NPATHS-1:0]            shd_en;
  logic [NPATHS-1:0][DLW-1:0]   shd_dly;
  cplx_t [NPATHS-1:0]           shd_gain;

  assign fld     = field_e'(cfg_addr[1:0]);
  assign pidx    = cfg_addr[CAW-1:2];
  assign wr_dly  = DLW'(clamp_dly(cfg_wdata, MIN_DELAY, DEPTH - 1));
  assign wr_gain = cfg_wdata;

  always_comb begin
    for (int p = 0; p < NPATHS; p++) begin
      path_hit[p] = cfg_we && (pidx == PIW'(p));
    end
  end

  // Shadow bank, loaded field by field
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_en   <= '0;
      shd_gain <= '0;
      for (int p = 0; p < NPATHS; p++) shd_dly[p] <= DLW'(MIN_DELAY);
    end else begin
      for (int p = 0; p < NPATHS; p++) begin
        if (path_hit[p]) begin
          case (fld)
            F_DELAY:  shd_dly[p]  <= wr_dly;
            F_GAIN:   shd_gain[p] <= wr_gain;
            F_ENABLE: shd_en[p]   <= cfg_wdata[0];
            default:  ;
          endcase
        end
      end
    end
  end

  // Active bank, swapped as a whole
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_en   <= '0;
      act_gain <= '0;
      for (int p = 0; p < NPATHS; p++) act_dly[p] <= DLW'(MIN_DELAY);
    end else if (cfg_commit) begin
      act_en   <= shd_en;
      act_dly  <= shd_dly;
      act_gain <= shd_gain;
    end
  end

  p_active_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_commit |=> ($stable(act_en) && $stable(act_dly) && $stable(act_gain)))
    else $error("active path set changed without a commit");

  always @(posedge clk) begin
    if (rst_n) begin
      for (int p = 0; p < NPATHS; p++) begin
        p_delay_legal_r5: assert ((int'(shd_dly[p]) >= MIN_DELAY) && (int'(shd_dly[p]) <= DEPTH - 1))
          else $error("shadow delay of path %0d out of range", p);
      end
    end
  end

endmodule

// File: rtl/mpe_delayline.sv
module mpe_delayline
  import mpe_pkg::*;
#(
  parameter int NPATHS = 10,
  parameter int DEPTH  = 1024,
  localparam int DLW = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  cplx_t                       wr_data,
  input  logic [NPATHS-1:0][DLW-1:0]  rd_dly,
  output cplx_t [NPATHS-1:0]          rd_data
);

  cplx_t             mem [DEPTH];
  logic [DLW-1:0]    wptr;
  logic [DLW:0]      fill;
  logic              wrap_evt;
  logic [DLW-1:0]    rd_addr [NPATHS];
  logic [NPATHS-1:0] rd_live;

  assign wrap_evt = wr_en && (wptr == DLW'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      fill <= '0;
    end else if (wr_en) begin
      wptr <= wrap_evt ? '0 : wptr + 1'b1;
      if (fill != (DLW + 1)'(DEPTH)) fill <= fill + 1'b1;
    end
  end

  // One read port per path; positions older than the fill level read as zero
  always_comb begin
    for (int p = 0; p < NPATHS; p++) begin
      if (wptr >= rd_dly[p]) rd_addr[p] = wptr - rd_dly[p];
      else                   rd_addr[p] = DLW'(DEPTH - int'(rd_dly[p]) + int'(wptr));
      rd_live[p] = ({1'b0, rd_dly[p]} <= fill);
      rd_data[p] = rd_live[p] ? mem[rd_addr[p]] : '0;
    end
  end

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(wptr) && $stable(fill)))
    else $error("history state moved without a write");

  p_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (wptr == '0))
    else $error("write position did not wrap to zero");

endmodule

// File: rtl/mpe_combiner.sv
module mpe_combiner
  import mpe_pkg::*;
#(
  parameter int NPATHS = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  input  cplx_t [NPATHS-1:0]  tap,
  input  cplx_t [NPATHS-1:0]  gain,
  input  logic [NPATHS-1:0]   en,
  output cplx_t               y
);

  cplx_t [NPATHS-1:0]   s1_tap;
  cplx_t [NPATHS-1:0]   s1_gain;
  logic [NPATHS-1:0]    s1_en;
  logic signed [PW-1:0] s2_re [NPATHS];
  logic signed [PW-1:0] s2_im [NPATHS];
  logic signed [ACCW-1:0] sum_re;
  logic signed [ACCW-1:0] sum_im;

  // Stage 1: capture taps together with the path set in force at acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_tap  <= '0;
      s1_gain <= '0;
      s1_en   <= '0;
    end else if (adv) begin
      s1_tap  <= tap;
      s1_gain <= gain;
      s1_en   <= en;
    end
  end

  // Stage 2: per-path complex products
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPATHS; p++) begin
        s2_re[p] <= '0;
        s2_im[p] <= '0;
      end
    end else if (adv) begin
      for (int p = 0; p < NPATHS; p++) begin
        s2_re[p] <= s1_en[p] ? cmul_re(s1_tap[p], s1_gain[p]) : '0;
        s2_im[p] <= s1_en[p] ? cmul_im(s1_tap[p], s1_gain[p]) : '0;
      end
    end
  end

  always_comb begin
    sum_re = '0;
    sum_im = '0;
    for (int p = 0; p < NPATHS; p++) begin
      sum_re = sum_re + ACCW'(s2_re[p]);
      sum_im = sum_im + ACCW'(s2_im[p]);
    end
  end

  // Stage 3: round and saturate
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   y <= '0;
    else if (adv) y <= {rnd_sat(sum_re), rnd_sat(sum_im)};
  end

endmodule

// File: rtl/mpath_chan_emu.sv
module mpath_chan_emu
  import mpe_pkg::*;
#(
  parameter int NPATHS    = 10,
  parameter int DEPTH     = 1024,
  parameter int MIN_DELAY = 4,
  localparam int PIW     = (NPATHS > 1) ? $clog2(NPATHS) : 1,
  localparam int CAW     = PIW + 2,
  localparam int DLW     = $clog2(DEPTH),
  localparam int LATENCY = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [SW-1:0] in_i,
  input  logic signed [SW-1:0] in_q,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [SW-1:0] out_i,
  output logic signed [SW-1:0] out_q,
  input  logic                 cfg_we,
  input  logic [CAW-1:0]       cfg_addr,
  input  logic [31:0]          cfg_wdata,
  input  logic                 cfg_commit
);

  logic [LATENCY-1:0]          vld;
  logic                        adv;
  logic                        acc;
  cplx_t                       in_smp;
  cplx_t                       y;
  logic [NPATHS-1:0]           act_en;
  logic [NPATHS-1:0][DLW-1:0]  act_dly;
  cplx_t [NPATHS-1:0]          act_gain;
  cplx_t [NPATHS-1:0]          taps;

  assign in_smp    = {in_i, in_q};
  assign adv       = !vld[LATENCY-1] || out_ready;
  assign acc       = in_valid && adv;
  assign in_ready  = adv;
  assign out_valid = vld[LATENCY-1];
  assign out_i     = y.re;
  assign out_q     = y.im;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   vld <= '0;
    else if (adv) vld <= {vld[LATENCY-2:0], acc};
  end

  mpe_pathbank #(
    .NPATHS(NPATHS), .DEPTH(DEPTH), .MIN_DELAY(MIN_DELAY)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_commit(cfg_commit),
    .act_en(act_en), .act_dly(act_dly), .act_gain(act_gain)
  );

  mpe_delayline #(
    .NPATHS(NPATHS), .DEPTH(DEPTH)
  ) u_hist (
    .clk(clk), .rst_n(rst_n),
    .wr_en(acc), .wr_data(in_smp),
    .rd_dly(act_dly), .rd_data(taps)
  );

  mpe_combiner #(
    .NPATHS(NPATHS)
  ) u_comb (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .tap(taps), .gain(act_gain), .en(act_en),
    .y(y)
  );

  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_i) && $stable(out_q)))
    else $error("output changed while stalled");

  p_no_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready))
    else $error("output sample vanished without a transfer");

endmodule

// File: tb/test_mpath_chan_emu.sv
module test_mpath_chan_emu;

  localparam int PERIOD = 10;
  localparam int NP     = 3;
  localparam int DP     = 16;
  localparam int MIND   = 2;
  localparam int NSTIM  = 20;

  localparam logic [31:0] STIM [NSTIM] = '{
    32'h1000_0000, 32'h0000_1000, 32'hF000_0800, 32'h0800_F800, 32'h2345_1234,
    32'hDCBA_0FED, 32'h7FFF_7FFF, 32'h8000_8000, 32'h0001_FFFF, 32'h4000_C000,
    32'h1111_2222, 32'hEEEE_DDDD, 32'h0555_0AAA, 32'hFAAA_F555, 32'h3000_0000,
    32'h0000_D000, 32'h6789_9876, 32'h0100_0200, 32'hFF00_FE00, 32'h7000_9000
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [15:0] in_i = '0;
  logic signed [15:0] in_q = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [15:0] out_i;
  logic signed [15:0] out_q;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic cfg_commit = 1'b0;

  always #(PERIOD / 2) clk = ~clk;

  mpath_chan_emu #(.NPATHS(NP), .DEPTH(DP), .MIN_DELAY(MIND)) i_mpath_chan_emu (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_ready(out_ready), .out_i(out_i), .out_q(out_q),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_commit(cfg_commit)
  );

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  // Reference model state
  int sh_en [NP], sh_d [NP], sh_ci [NP], sh_cq [NP];
  int ac_en [NP], ac_d [NP], ac_ci [NP], ac_cq [NP];
  int hist_i [1024], hist_q [1024];
  int nacc = 0;
  int exp_i [1024], exp_q [1024];
  string exp_tag [1024];
  int wr_n = 0, rd_n = 0;

  function automatic int sat16(longint s);
    longint t;
    t = (s + 16384) >>> 15;
    if (t > 32767) return 32767;
    if (t < -32768) return -32768;
    return int'(t);
  endfunction

  task automatic check(input string req, input bit ok, input int act, input int expv, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic send(input int xi, input int xq);
    longint sr, si;
    @(negedge clk);
    in_valid = 1'b1;
    in_i = 16'(xi);
    in_q = 16'(xq);
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    hist_i[nacc] = int'($signed(16'(xi)));
    hist_q[nacc] = int'($signed(16'(xq)));
    sr = 0;
    si = 0;
    for (int p = 0; p < NP; p++) begin
      if (ac_en[p] != 0 && nacc >= ac_d[p]) begin
        sr += longint'(hist_i[nacc - ac_d[p]]) * ac_ci[p] - longint'(hist_q[nacc - ac_d[p]]) * ac_cq[p];
        si += longint'(hist_i[nacc - ac_d[p]]) * ac_cq[p] + longint'(hist_q[nacc - ac_d[p]]) * ac_ci[p];
      end
    end
    nacc++;
    exp_i[wr_n] = sat16(sr);
    exp_q[wr_n] = sat16(si);
    exp_tag[wr_n] = tag;
    wr_n++;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // R10 address layout: {path, field}; field 0 delay, 1 gain, 2 enable
  task automatic cfg(input int p, input int f, input logic [31:0] d);
    @(negedge clk);
    in_valid = 1'b0;
    cfg_we = 1'b1;
    cfg_addr = {2'(p), 2'(f)};
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (p < NP) begin
      case (f)
        0: sh_d[p] = (d < MIND) ? MIND : ((d > DP - 1) ? DP - 1 : int'(d));
        1: begin
          sh_ci[p] = int'($signed(d[31:16]));
          sh_cq[p] = int'($signed(d[15:0]));
        end
        2: sh_en[p] = int'(d[0]);
        default: ;
      endcase
    end
  endtask

  task automatic commit();
    @(negedge clk);
    in_valid = 1'b0;
    cfg_commit = 1'b1;
    @(negedge clk);
    cfg_commit = 1'b0;
    ac_en = sh_en;
    ac_d = sh_d;
    ac_ci = sh_ci;
    ac_cq = sh_cq;
  endtask

  // Output monitor, sampled well after the falling edge
  always @(negedge clk) begin
    #2;
    if (rst_n && out_valid && out_ready) begin
      if (rd_n >= wr_n) begin
        check("R8", 1'b0, rd_n, wr_n, "unexpected extra output, index");
      end else begin
        check(exp_tag[rd_n], int'(out_i) == exp_i[rd_n], int'(out_i), exp_i[rd_n], $sformatf("out_i of sample %0d", rd_n));
        check(exp_tag[rd_n], int'(out_q) == exp_q[rd_n], int'(out_q), exp_q[rd_n], $sformatf("out_q of sample %0d", rd_n));
      end
      rd_n++;
    end
  end

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL R8 watchdog expired: actual hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hold_i, hold_q;
    for (int p = 0; p < NP; p++) begin
      sh_en[p] = 0; sh_d[p] = MIND; sh_ci[p] = 0; sh_cq[p] = 0;
    end
    ac_en = sh_en; ac_d = sh_d; ac_ci = sh_ci; ac_cq = sh_cq;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #3;
    // R1: reset state
    check("R1", out_valid == 1'b0, int'(out_valid), 0, "out_valid after reset");
    check("R1", in_ready == 1'b1, int'(in_ready), 1, "in_ready after reset");
    tag = "R1";
    send(100, -50);
    send(-7, 3000);
    send(12345, 1);
    idle(5);

    // R5 clamp at both ends, R10 map
    cfg(0, 0, 32'd1);
    cfg(0, 1, 32'h4000_0000);
    cfg(0, 2, 32'd1);
    cfg(1, 0, 32'd5);
    cfg(1, 1, 32'h0000_2000);
    cfg(1, 2, 32'd1);
    cfg(2, 0, 32'd100);
    cfg(2, 1, 32'hC000_4000);
    cfg(2, 2, 32'd1);
    cfg(0, 3, 32'hFFFF_FFFF);
    cfg(3, 1, 32'h7FFF_7FFF);
    cfg(3, 2, 32'd1);
    // R6: shadow writes invisible before commit
    tag = "R6";
    send(2000, -2000);
    send(-3000, 4000);
    idle(5);
    commit();

    // Vector table walk: early zero reads, main function, wraparound
    for (int k = 0; k < 2 * NSTIM; k++) begin
      tag = (k < 8) ? "R4" : ((k < NSTIM) ? "R2" : "R11");
      send(int'($signed(STIM[k % NSTIM][31:16])), int'($signed(STIM[k % NSTIM][15:0])));
    end
    idle(5);

    // R10: writes to spare field and absent path leave the set unchanged
    tag = "R10";
    cfg(1, 3, 32'h0000_0001);
    cfg(3, 0, 32'd7);
    commit();
    for (int k = 0; k < 6; k++) send(int'($signed(STIM[k][31:16])), int'($signed(STIM[k][15:0])));

    // R7: disable then re-enable without rewriting delay or gain
    tag = "R7";
    cfg(1, 2, 32'd0);
    commit();
    for (int k = 6; k < 12; k++) send(int'($signed(STIM[k][31:16])), int'($signed(STIM[k][15:0])));
    cfg(1, 2, 32'd1);
    commit();
    for (int k = 12; k < 18; k++) send(int'($signed(STIM[k][31:16])), int'($signed(STIM[k][15:0])));
    idle(5);

    // R3: rounding boundary with a one-LSB gain
    tag = "R3";
    cfg(0, 0, 32'd2);
    cfg(0, 1, 32'h0001_0000);
    cfg(1, 2, 32'd0);
    cfg(2, 2, 32'd0);
    commit();
    send(16384, 16383);
    send(-16384, -16385);
    send(16383, 16384);
    send(0, 0);
    send(0, 0);
    // R3: saturation in both directions with three full-scale paths
    cfg(0, 1, 32'h7FFF_0000);
    cfg(1, 1, 32'h7FFF_0000);
    cfg(2, 1, 32'h7FFF_0000);
    cfg(1, 2, 32'd1);
    cfg(2, 2, 32'd1);
    commit();
    for (int k = 0; k < 16; k++) send(32767, -32768);
    for (int k = 0; k < 16; k++) send(-32768, 32767);
    idle(6);

    // R8: fixed latency, pipeline empty beforehand
    tag = "R8";
    send(500, 500);
    @(negedge clk);
    in_valid = 1'b0;
    #3;
    check("R8", out_valid == 1'b0, int'(out_valid), 0, "out_valid after accepting edge");
    @(negedge clk);
    #3;
    check("R8", out_valid == 1'b0, int'(out_valid), 0, "out_valid one edge later");
    @(negedge clk);
    #3;
    check("R8", out_valid == 1'b1, int'(out_valid), 1, "out_valid two edges later");
    idle(6);

    // R9: backpressure holds output and blocks input
    tag = "R9";
    @(negedge clk);
    out_ready = 1'b0;
    send(1000, 2000);
    send(-1000, 3000);
    send(4000, -5000);
    @(negedge clk);
    in_valid = 1'b0;
    #3;
    check("R9", in_ready == 1'b0, int'(in_ready), 0, "in_ready while stalled");
    check("R9", out_valid == 1'b1, int'(out_valid), 1, "out_valid while stalled");
    hold_i = int'(out_i);
    hold_q = int'(out_q);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      #3;
      check("R9", out_valid == 1'b1, int'(out_valid), 1, "out_valid held");
      check("R9", int'(out_i) == hold_i, int'(out_i), hold_i, "out_i held");
      check("R9", int'(out_q) == hold_q, int'(out_q), hold_q, "out_q held");
    end
    @(negedge clk);
    out_ready = 1'b1;
    idle(8);

    check("R8", rd_n == wr_n, rd_n, wr_n, "outputs received versus samples accepted");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule